// File: doc/BRIEF.md
# Burst-of-Four Write Capture Unit

This block sits on the write side of a single-clock synchronous memory interface. A write command is one rising-edge sample of the command pins with both the read/write select and the load strobe low. It is followed by four 18-bit data beats over the next two clock cycles. The double-rate data bus is modelled as two buses sampled on the same rising edge. The rise bus carries the beat that would arrive on the rising edge. The fall bus carries the beat that would arrive on the following falling edge.

The unit latches the command address. It seeds a two-bit burst counter from the address's low bits and steers each beat into its place in a 72-bit, four-word group. The counter wraps inside that aligned group. Each beat carries two active-low byte-lane selects. When the fourth beat has arrived, the unit emits one registered, single-cycle write pulse to a behavioural array port. The pulse carries the group address, the 72-bit data word and an 8-bit lane-enable mask. Commands may be issued every second cycle, which keeps the data bus busy on every edge. A command on the edge right after an accepted one is dropped.

Top module: `burst4_write_capture`

## Requirements
- R1: A write is accepted on a rising edge where `wr_rd_n` and `load_n` are both sampled low, unless the previous edge accepted a write. A read command (`wr_rd_n` high) or an unloaded cycle (`load_n` high) starts no write.
- R2: The committed `mem_addr` equals bits ADDR_W-1:2 of the `cmd_addr` sampled with the accepted command.
- R3: With start slot a = `cmd_addr[1:0]`, a command on edge T is followed by data beats k = 0..3. Beat 0 is on `rise_data` and beat 1 on `fall_data` at edge T+1. Beats 2 and 3 arrive the same way at edge T+2. Beat k lands in slot (a+k) mod 4, and slot w occupies `mem_wdata[18w+17:18w]`.
- R4: Each beat's select bit 0 governs its bits 8:0 and select bit 1 its bits 17:9. A select sampled low enables the lane. `mem_lane_mask` bit 2w+L is 1 exactly when lane L of slot w was enabled.
- R5: Every 9-bit lane of `mem_wdata` whose mask bit is 0 reads zero during a commit, so that lane of the array is left unchanged.
- R6: `mem_we` is registered on edge T+2 and stays high for exactly one cycle per accepted write.
- R7: A command on edge T+1 is ignored. No pulse follows at T+3, and the pending write's address and data are not disturbed.
- R8: A command on edge T+2 is accepted. A stream of commands every second edge gives one pulse every second cycle, each with its own address and data.
- R9: While no write is pending, data and select activity gives no pulse. A pending write completes whatever the command pins do during its data cycles.
- R10: During reset and until the first commit, `mem_we` is 0 and `mem_addr`, `mem_wdata` and `mem_lane_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_rd_n | input | 1 | Read/write select, low for write |
| load_n | input | 1 | Command load strobe, active low |
| cmd_addr | input | ADDR_W | Command address; bits 1:0 seed the burst counter |
| rise_data | input | 18 | Beat sampled in the rising half of a data cycle |
| rise_sel_n | input | 2 | Active-low lane selects for the rise beat |
| fall_data | input | 18 | Beat sampled in the falling half of a data cycle |
| fall_sel_n | input | 2 | Active-low lane selects for the fall beat |
| mem_we | output | 1 | Single-cycle array write pulse |
| mem_addr | output | ADDR_W-2 | Four-word group address of the write |
| mem_wdata | output | 72 | Assembled group, slot w at bits 18w+17:18w |
| mem_lane_mask | output | 8 | Lane enables, bit 2w+L for lane L of slot w |

## Verification
Two things can happen on the same edge: the last data beats of one write are taken in and committed, and the next command is accepted and its address and counter seed are loaded. The stream test issues a command on every second edge with changing start slots and select patterns. Every pulse must then carry its own group address and data, not those of its neighbour. A third command placed on the edge between two accepted ones must leave no trace in either commit or in the pulse spacing.

// File: rtl/burst4_pkg.sv
package burst4_pkg;
  localparam int unsigned BEATS  = 4;
  localparam int unsigned SLOT_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_LAST  = 2'd2
  } phase_e;
endpackage

// File: rtl/burst4_cmd_ctrl.sv
module burst4_cmd_ctrl
  import burst4_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned GRP_W = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rd_n,
  input  logic              load_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cap_first,
  output logic              cap_last,
  output logic [SLOT_W-1:0] slot_base,
  output logic [GRP_W-1:0]  grp_addr
);
  phase_e            phase_q, phase_d;
  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic [GRP_W-1:0]  grp_q;
  logic              wr_req, accept;

  assign wr_req = !wr_rd_n && !load_n;
  assign accept = wr_req && (phase_q != PH_FIRST);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE:  phase_d = accept ? PH_FIRST : PH_IDLE;
      PH_FIRST: begin
        phase_d = PH_LAST;
        cnt_d   = cnt_q + SLOT_W'(2);
      end
      PH_LAST:  phase_d = accept ? PH_FIRST : PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
    if (accept) cnt_d = cmd_addr[SLOT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      grp_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (accept) grp_q <= cmd_addr[ADDR_W-1:SLOT_W];
    end
  end

  assign cap_first = (phase_q == PH_FIRST);
  assign cap_last  = (phase_q == PH_LAST);
  assign slot_base = cnt_q;
  assign grp_addr  = grp_q;

  // R1 / R2: a qualifying command opens a burst and captures its group address
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && phase_q != PH_FIRST) |=>
      (phase_q == PH_FIRST && grp_q == $past(cmd_addr[ADDR_W-1:SLOT_W])));

  // R3: the first data cycle is always followed by the second
  p_two_data_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FIRST) |=> (phase_q == PH_LAST));

  // R7: a command in the first data cycle changes neither address nor slot order
  p_drop_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FIRST && wr_req) |=>
      ($stable(grp_q) && cnt_q == $past(cnt_q) + SLOT_W'(2)));
endmodule

// File: rtl/burst4_beat_assembler.sv
module burst4_beat_assembler
  import burst4_pkg::*;
#(
  parameter int unsigned BEAT_W = 18,
  parameter int unsigned LANES  = 2,
  localparam int unsigned LANE_W = BEAT_W / LANES,
  localparam int unsigned WORD_W = BEATS * BEAT_W,
  localparam int unsigned MASK_W = BEATS * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_first,
  input  logic [SLOT_W-1:0] slot_base,
  input  logic [BEAT_W-1:0] rise_data,
  input  logic [LANES-1:0]  rise_sel_n,
  input  logic [BEAT_W-1:0] fall_data,
  input  logic [LANES-1:0]  fall_sel_n,
  output logic [WORD_W-1:0] word_data,
  output logic [MASK_W-1:0] word_mask
);
  logic [WORD_W-1:0] held_data_q;
  logic [MASK_W-1:0] held_mask_q;
  logic [SLOT_W-1:0] fall_slot;

  assign fall_slot = slot_base + SLOT_W'(1);

  for (genvar s = 0; s < BEATS; s++) begin : g_slot
    logic rise_hit, fall_hit;
    assign rise_hit = (slot_base == SLOT_W'(s));
    assign fall_hit = (fall_slot == SLOT_W'(s));
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int unsigned DB = s * BEAT_W + l * LANE_W;
      localparam int unsigned MB = s * LANES + l;
      logic [LANE_W-1:0] rise_lane, fall_lane;
      assign rise_lane = rise_sel_n[l] ? '0 : rise_data[l*LANE_W +: LANE_W];
      assign fall_lane = fall_sel_n[l] ? '0 : fall_data[l*LANE_W +: LANE_W];
      assign word_data[DB +: LANE_W] = rise_hit ? rise_lane :
                                       fall_hit ? fall_lane :
                                       held_data_q[DB +: LANE_W];
      assign word_mask[MB] = rise_hit ? !rise_sel_n[l] :
                             fall_hit ? !fall_sel_n[l] :
                             held_mask_q[MB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held_mask_q <= '0;
    else if (cap_first) held_mask_q <= word_mask;
  end

  always_ff @(posedge clk) begin
    if (cap_first) held_data_q <= word_data;
  end
endmodule

// File: rtl/burst4_write_capture.sv
module burst4_write_capture
  import burst4_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BEAT_W = 18,
  parameter int unsigned LANES  = 2,
  localparam int unsigned LANE_W = BEAT_W / LANES,
  localparam int unsigned GRP_W  = ADDR_W - SLOT_W,
  localparam int unsigned WORD_W = BEATS * BEAT_W,
  localparam int unsigned MASK_W = BEATS * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rd_n,
  input  logic              load_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BEAT_W-1:0] rise_data,
  input  logic [LANES-1:0]  rise_sel_n,
  input  logic [BEAT_W-1:0] fall_data,
  input  logic [LANES-1:0]  fall_sel_n,
  output logic              mem_we,
  output logic [GRP_W-1:0]  mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [MASK_W-1:0] mem_lane_mask
);
  logic              rst_meta_q, rst_sync_q;
  logic              cap_first, cap_last;
  logic [SLOT_W-1:0] slot_base;
  logic [GRP_W-1:0]  grp_addr;
  logic [WORD_W-1:0] word_data;
  logic [MASK_W-1:0] word_mask;
  logic              we_d;
  logic [GRP_W-1:0]  addr_d;
  logic [WORD_W-1:0] wdata_d;
  logic [MASK_W-1:0] mask_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  burst4_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_rd_n   (wr_rd_n),
    .load_n    (load_n),
    .cmd_addr  (cmd_addr),
    .cap_first (cap_first),
    .cap_last  (cap_last),
    .slot_base (slot_base),
    .grp_addr  (grp_addr)
  );

  burst4_beat_assembler #(.BEAT_W(BEAT_W), .LANES(LANES)) u_asm (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .cap_first  (cap_first),
    .slot_base  (slot_base),
    .rise_data  (rise_data),
    .rise_sel_n (rise_sel_n),
    .fall_data  (fall_data),
    .fall_sel_n (fall_sel_n),
    .word_data  (word_data),
    .word_mask  (word_mask)
  );

  always_comb begin
    we_d    = cap_last;
    addr_d  = mem_addr;
    wdata_d = mem_wdata;
    mask_d  = mem_lane_mask;
    if (cap_last) begin
      addr_d  = grp_addr;
      wdata_d = word_data;
      mask_d  = word_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      mem_lane_mask <= '0;
    end else begin
      mem_we        <= we_d;
      mem_addr      <= addr_d;
      mem_wdata     <= wdata_d;
      mem_lane_mask <= mask_d;
    end
  end

  logic [WORD_W-1:0] lane_fill;
  for (genvar m = 0; m < MASK_W; m++) begin : g_fill
    assign lane_fill[m*LANE_W +: LANE_W] = {LANE_W{mem_lane_mask[m]}};
  end

  // R5: disabled lanes carry zero on the array port
  p_masked_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_we |-> ((mem_wdata & ~lane_fill) == '0));

  // R6: the pulse lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_we |=> !mem_we);

  // R6 / R9: a pulse follows the second data cycle and nothing else
  p_pulse_source_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(mem_we) |-> $past(cap_last));
endmodule

// File: tb/burst4_write_capture_bench.sv
module burst4_write_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_rd_n, load_n;
  logic [ADDR_W-1:0] cmd_addr;
  logic [17:0] rise_data, fall_data;
  logic [1:0]  rise_sel_n, fall_sel_n;
  logic        mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [71:0] mem_wdata;
  logic [7:0]  mem_lane_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [17:0] bd [4];
  logic [1:0]  bn [4];
  logic [71:0] exp_d;
  logic [7:0]  exp_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst4_write_capture #(.ADDR_W(ADDR_W)) u_burst4_write_capture (
    .clk(clk), .rst_n(rst_n), .wr_rd_n(wr_rd_n), .load_n(load_n),
    .cmd_addr(cmd_addr), .rise_data(rise_data), .rise_sel_n(rise_sel_n),
    .fall_data(fall_data), .fall_sel_n(fall_sel_n), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_lane_mask(mem_lane_mask)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // expected group from bd/bn and the start slot
  task automatic make_exp(input logic [1:0] a);
    exp_d = '0;
    exp_m = '0;
    for (int k = 0; k < 4; k++) begin
      int slot;
      slot = (int'(a) + k) % 4;
      for (int l = 0; l < 2; l++) begin
        if (!bn[k][l]) begin
          exp_d[slot*18 + l*9 +: 9] = bd[k][l*9 +: 9];
          exp_m[slot*2 + l] = 1'b1;
        end
      end
    end
  endtask

  task automatic stream_pattern(input int n);
    for (int k = 0; k < 4; k++) begin
      bd[k] = 18'(n*7919 + k*613 + 11);
      bn[k] = 2'(n + k);
    end
  endtask

  task automatic idle_cmd(input logic wr);
    wr_rd_n = wr;
    load_n  = 1'b1;
  endtask

  task automatic put_cmd(input logic [ADDR_W-1:0] a);
    wr_rd_n  = 1'b0;
    load_n   = 1'b0;
    cmd_addr = a;
  endtask

  task automatic put_beats(input int half);
    rise_data  = bd[2*half];
    rise_sel_n = bn[2*half];
    fall_data  = bd[2*half+1];
    fall_sel_n = bn[2*half+1];
  endtask

  task automatic junk_beats(input int seed);
    rise_data  = 18'(seed*3 + 99);
    fall_data  = 18'(seed*5 + 7);
    rise_sel_n = 2'(seed);
    fall_sel_n = 2'(seed + 1);
  endtask

  task automatic check_commit(input string tag, input logic [ADDR_W-1:0] a);
    make_exp(a[1:0]);
    chk({tag, " R6 we"}, 72'(mem_we), 72'd1);
    chk({tag, " R2 addr"}, 72'(mem_addr), 72'(a[ADDR_W-1:2]));
    chk({tag, " R3/R5 data"}, mem_wdata, exp_d);
    chk({tag, " R4 mask"}, 72'(mem_lane_mask), 72'(exp_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_cmd(1'b1);
    cmd_addr = '0;
    junk_beats(0);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset we", 72'(mem_we), 72'd0);
    chk("R10 reset mask", 72'(mem_lane_mask), 72'd0);
    chk("R10 reset data", mem_wdata, 72'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 post-reset we", 72'(mem_we), 72'd0);
    chk("R10 post-reset addr", 72'(mem_addr), 72'd0);

    // R1/R9: read commands, unloaded cycles and bus activity start nothing
    for (int i = 0; i < 12; i++) begin
      wr_rd_n = i[0];
      load_n  = ~i[0];
      cmd_addr = ADDR_W'(i * 37);
      junk_beats(i);
      @(posedge clk);
      @(negedge clk);
      chk("R1/R9 no write while idle", 72'(mem_we), 72'd0);
    end

    // R3/R4/R5/R2/R6/R9: every start slot against every select pattern
    for (int a = 0; a < 4; a++) begin
      for (int it = 0; it < 256; it++) begin
        logic [ADDR_W-1:0] addr;
        for (int k = 0; k < 4; k++) begin
          bd[k] = 18'(it*4099 + k*257 + a*31 + 5);
          bn[k] = 2'(it >> (2*k));
        end
        addr = {8'(it*13 + a), 2'(a)};
        put_cmd(addr);
        @(posedge clk);
        @(negedge clk);
        idle_cmd(1'(it));          // R9: pending write ignores command pins
        put_beats(0);
        @(posedge clk);
        @(negedge clk);
        chk("R6 no early pulse", 72'(mem_we), 72'd0);
        put_beats(1);
        @(posedge clk);
        @(negedge clk);
        check_commit("sweep", addr);
        junk_beats(it);
      end
    end

    // R7/R8: command between two accepted ones is dropped
    begin
      logic [ADDR_W-1:0] a_first, a_drop, a_third;
      logic [17:0] d3 [4];
      logic [1:0]  n3 [4];
      a_first = 10'h1E6; a_drop = 10'h0A1; a_third = 10'h333;
      stream_pattern(40);
      put_cmd(a_first);
      @(posedge clk); @(negedge clk);
      put_cmd(a_drop);
      put_beats(0);
      @(posedge clk); @(negedge clk);
      put_cmd(a_third);
      put_beats(1);
      @(posedge clk); @(negedge clk);
      check_commit("R7 first", a_first);
      idle_cmd(1'b1);
      stream_pattern(41);
      for (int k = 0; k < 4; k++) begin d3[k] = bd[k]; n3[k] = bn[k]; end
      put_beats(0);
      @(posedge clk); @(negedge clk);
      chk("R7 dropped command gives no pulse", 72'(mem_we), 72'd0);
      put_beats(1);
      @(posedge clk); @(negedge clk);
      for (int k = 0; k < 4; k++) begin bd[k] = d3[k]; bn[k] = n3[k]; end
      check_commit("R8 third", a_third);
      junk_beats(3);
      @(posedge clk); @(negedge clk);
      chk("R6 pulse ends", 72'(mem_we), 72'd0);
    end

    // R8: command every second edge, commit and next accept on one edge
    begin
      localparam int N = 8;
      for (int i = 0; i <= 2*N + 1; i++) begin
        if (i % 2 == 0 && i / 2 < N) put_cmd(ADDR_W'(i/2 * 97 + i/2));
        else idle_cmd(1'b0);
        if (i % 2 == 1 && (i-1)/2 < N) begin
          stream_pattern((i-1)/2);
          put_beats(0);
        end else if (i % 2 == 0 && i >= 2) begin
          stream_pattern(i/2 - 1);
          put_beats(1);
        end else junk_beats(i);
        @(posedge clk); @(negedge clk);
        if (i % 2 == 0 && i >= 2) begin
          stream_pattern(i/2 - 1);
          check_commit("R8 stream", ADDR_W'((i/2-1) * 97 + (i/2-1)));
        end else begin
          chk("R8 gap between pulses", 72'(mem_we), 72'd0);
        end
      end
    end

    idle_cmd(1'b1);
    repeat (3) @(negedge clk);
    chk("R9 quiet after stream", 72'(mem_we), 72'd0);
    finish_run();
  end
endmodule